// File: doc/BRIEF.md
# Symmetric PWM Gate Modulator with Soft-Start and Peak-Current Cutoff

This block drives the single power switch of a switched-mode converter. An up-down carrier counter sweeps from zero to a programmed peak value and back, so one switching period takes twice the peak value in clock cycles. The gate is on while the carrier sits above a threshold that the effective compare value sets. The on pulse is therefore centred on the carrier peak, and at that peak a one-cycle strobe starts the converter's feedback ADC. The sample lands as far as possible from both switching edges, where the switching noise is lowest.

The effective compare value is the smallest of three terms: the duty word from the control loop, a soft-start ceiling, and a fixed maximum near 65% of the period. The ceiling starts at zero when the modulator is enabled and rises in steps every few periods, so the converter does not start at full duty into an uncharged output capacitor. A digital overcurrent input from an external peak-current comparator sets a latch. The latch blanks the gate until the next carrier valley, and a sticky flag records that a trip occurred. The duty word and the period are taken in only at the valley, so a pulse never changes shape while it is under way.

Top module: `cpwm_gate`

## Requirements
- R1: The carrier C counts 0,1,..,P,P-1,..,1 and repeats, a period of 2P cycles, where P is the period shadow (a period input below 2 is taken as 2). The gate is high in the cycles where C + K > P, K being the effective compare value, which gives 2K-1 high cycles per period for K >= 1 and none for K = 0.
- R2: While enabled, the ADC trigger is high for exactly one cycle per period, in the cycle where C = P (P cycles after the valley cycle).
- R3: The duty and period inputs are captured only in the valley cycle (C = 0). A change at any other time does not alter the pulse under way and takes effect in the next period.
- R4: K = min(duty shadow, soft-start ceiling, floor(P*166/256)).
- R5: The ceiling is 0 while disabled. From enable, every valley is counted. At every 4th valley the ceiling becomes min(ceiling + step, floor(P*166/256)), so the first three periods after enable have no gate pulse.
- R6: While enable is low, the gate and the ADC trigger are low, the ceiling is held at 0 and the carrier waits at 0.
- R7: An overcurrent input high in an enabled, non-valley cycle sets the trip latch (shown on trip_active_o) from the next cycle on. The gate stays low until the latch clears in the next valley cycle. An overcurrent in the valley cycle has no effect.
- R8: The trip flag is set by the same event that sets the latch and stays high until a cycle with the clear input high and no new trip. A trip in the same cycle as a clear wins.
- R9: ramp_done_o is high when the ceiling has reached floor(P*166/256).
- R10: After reset all outputs are low, the period shadow is 2, and the duty shadow and the ceiling are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Modulator enable; low also restarts soft-start |
| duty_i | input | CW | Requested compare value (about duty times P) |
| period_i | input | CW | Carrier peak value P |
| ramp_step_i | input | SW | Ceiling increment per ramp interval |
| oc_i | input | 1 | Peak-current comparator output |
| trip_clr_i | input | 1 | Clears the sticky trip flag |
| gate_o | output | 1 | Switch gate drive |
| adc_trig_o | output | 1 | ADC start strobe at pulse centre |
| trip_active_o | output | 1 | Trip latch state |
| trip_flag_o | output | 1 | Sticky trip record |
| ramp_done_o | output | 1 | Soft-start ceiling at its limit |

## Verification
The bench rewrites a duty request in the middle of a pulse. A design that loaded it at once would give a truncated or stretched pulse in that period instead of the old width followed by the new one. It fires the overcurrent input part-way up the pulse and again exactly on the valley. A latch that cleared too early would let the gate return within the same period, and one that accepted the valley event would leave the flag set with no pulse to cut. It also drops and raises the enable to check that the ramp restarts from zero. It requests more than the maximum duty and asks for a period below two, where a wrong clamp shows up as a wider pulse or a carrier that stalls.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {CNT_UP = 1'b0, CNT_DN = 1'b1} cnt_dir_e;

  // Period values below two would leave the carrier with no down slope.
  function automatic int unsigned legal_period(int unsigned p);
    return (p < 2) ? 2 : p;
  endfunction

  // Hard duty ceiling as a fixed fraction num / 2**sh of the peak value.
  function automatic int unsigned duty_ceiling_of(int unsigned p, int unsigned num,
                                                  int unsigned sh);
    return (p * num) >> sh;
  endfunction

  function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // One soft-start increment, saturating at the hard limit.
  function automatic int unsigned ramp_next(int unsigned cur, int unsigned step,
                                            int unsigned lim);
    return (cur + step > lim) ? lim : cur + step;
  endfunction

endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          valley_o,
  output logic          peak_o
);

  cnt_dir_e      dir_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
    end else if (!en_i) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
    end else if (dir_q == CNT_UP) begin
      if (cnt_q >= per_i) begin
        cnt_q <= cnt_q - 1'b1;
        dir_q <= CNT_DN;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) dir_q <= CNT_UP;
    end
  end

  assign cnt_o    = cnt_q;
  assign valley_o = (cnt_q == '0);
  assign peak_o   = (cnt_q == per_i);

endmodule

// File: rtl/cpwm_softstart.sv
module cpwm_softstart
  import cpwm_pkg::*;
#(
  parameter int CW           = 10,
  parameter int SW           = 6,
  parameter int RAMP_PERIODS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valley_i,
  input  logic [SW-1:0] step_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] ceil_o,
  output logic          done_o
);

  localparam int RCW = (RAMP_PERIODS > 1) ? $clog2(RAMP_PERIODS) : 1;
  localparam logic [RCW-1:0] RC_LAST = RCW'(RAMP_PERIODS - 1);

  logic [RCW-1:0] rc_q;
  logic [CW-1:0]  ceil_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q   <= '0;
      ceil_q <= '0;
    end else if (!en_i) begin
      rc_q   <= '0;
      ceil_q <= '0;
    end else if (valley_i) begin
      if (rc_q == RC_LAST) begin
        rc_q   <= '0;
        ceil_q <= CW'(ramp_next(32'(ceil_q), 32'(step_i), 32'(lim_i)));
      end else begin
        rc_q <= rc_q + 1'b1;
      end
    end
  end

  assign ceil_o = ceil_q;
  assign done_o = (ceil_q >= lim_i);

endmodule

// File: rtl/cpwm_trip.sv
module cpwm_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valley_i,
  input  logic oc_i,
  input  logic clr_i,
  output logic trip_o,
  output logic flag_o
);

  logic trip_q;
  logic flag_q;
  logic trip_event;

  assign trip_event = en_i && !valley_i && oc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (!en_i || valley_i) trip_q <= 1'b0;
      else if (oc_i)         trip_q <= 1'b1;
      flag_q <= trip_event | (flag_q & ~clr_i);
    end
  end

  assign trip_o = trip_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate
  import cpwm_pkg::*;
#(
  parameter int CW           = 10,
  parameter int SW           = 6,
  parameter int RAMP_PERIODS = 4,
  parameter int LIM_NUM      = 166,
  parameter int LIM_SH       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] period_i,
  input  logic [SW-1:0] ramp_step_i,
  input  logic          oc_i,
  input  logic          trip_clr_i,
  output logic          gate_o,
  output logic          adc_trig_o,
  output logic          trip_active_o,
  output logic          trip_flag_o,
  output logic          ramp_done_o
);

  logic [CW-1:0] cnt;
  logic          valley;
  logic          peak;
  logic [CW-1:0] per_sh;
  logic [CW-1:0] duty_sh;
  logic [CW-1:0] ceil;
  logic [CW-1:0] duty_lim;
  logic [CW-1:0] cmp_eff;
  logic          trip_q;
  logic          above;

  // Shadow capture, valley only.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh  <= CW'(2);
      duty_sh <= '0;
    end else if (valley) begin
      per_sh  <= CW'(legal_period(32'(period_i)));
      duty_sh <= duty_i;
    end
  end

  assign duty_lim = CW'(duty_ceiling_of(32'(per_sh), 32'(LIM_NUM), 32'(LIM_SH)));
  assign cmp_eff  = CW'(min3(32'(duty_sh), 32'(ceil), 32'(duty_lim)));

  cpwm_carrier #(.CW(CW)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .per_i    (per_sh),
    .cnt_o    (cnt),
    .valley_o (valley),
    .peak_o   (peak)
  );

  cpwm_softstart #(.CW(CW), .SW(SW), .RAMP_PERIODS(RAMP_PERIODS)) u_soft (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valley_i (valley),
    .step_i   (ramp_step_i),
    .lim_i    (duty_lim),
    .ceil_o   (ceil),
    .done_o   (ramp_done_o)
  );

  cpwm_trip u_trip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valley_i (valley),
    .oc_i     (oc_i),
    .clr_i    (trip_clr_i),
    .trip_o   (trip_q),
    .flag_o   (trip_flag_o)
  );

  assign above         = ({1'b0, cnt} + {1'b0, cmp_eff}) > {1'b0, per_sh};
  assign gate_o        = en_i && !trip_q && above;
  assign adc_trig_o    = en_i && peak;
  assign trip_active_o = trip_q;

endmodule

// File: rtl/cpwm_gate_chk.sv
module cpwm_gate_chk #(
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          oc_i,
  input logic          trip_clr_i,
  input logic          gate_o,
  input logic          adc_trig_o,
  input logic          trip_flag_o,
  input logic          valley,
  input logic [CW-1:0] ceil,
  input logic [CW-1:0] cmp_eff
);

  assert_gate_off_at_valley_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valley |-> !gate_o);

  assert_single_adc_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_trig_o |=> !adc_trig_o);

  assert_compare_held_in_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(valley)) |-> $stable(cmp_eff));

  assert_ceiling_moves_at_valley_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(valley)) |-> $stable(ceil));

  assert_disabled_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!gate_o && !adc_trig_o));

  assert_trip_blanks_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valley && oc_i) |=> !gate_o);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_flag_o && !trip_clr_i) |=> trip_flag_o);

endmodule

bind cpwm_gate cpwm_gate_chk #(.CW(CW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .oc_i        (oc_i),
  .trip_clr_i  (trip_clr_i),
  .gate_o      (gate_o),
  .adc_trig_o  (adc_trig_o),
  .trip_flag_o (trip_flag_o),
  .valley      (valley),
  .ceil        (ceil),
  .cmp_eff     (cmp_eff)
);

// File: tb/cpwm_gate_tb_top.sv
module cpwm_gate_tb_top;

  localparam int CW = 10;
  localparam int SW = 6;
  localparam int RP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] duty = '0;
  logic [CW-1:0] per = '0;
  logic [SW-1:0] step = '0;
  logic          oc = 1'b0;
  logic          clr = 1'b0;
  logic          gate, adc, trip_act, tflag, rdone;

  always #10 clk = ~clk;  // 50 MHz

  cpwm_gate #(.CW(CW), .SW(SW), .RAMP_PERIODS(RP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .duty_i(duty), .period_i(per),
    .ramp_step_i(step), .oc_i(oc), .trip_clr_i(clr), .gate_o(gate),
    .adc_trig_o(adc), .trip_active_o(trip_act), .trip_flag_o(tflag),
    .ramp_done_o(rdone)
  );

  // staged stimulus, applied at the falling edge
  int s_rst_n = 0, s_en = 0, s_duty = 0, s_per = 0, s_step = 0, s_oc = 0, s_clr = 0;

  // behavioural reference state
  int m_cnt = 0, m_up = 1, m_per = 2, m_duty = 0, m_ceil = 0, m_rc = 0, m_trip = 0, m_flag = 0;

  int n_chk = 0, n_fail = 0;
  int gacc = 0, last_width = 0, since_v = 0, adc_pos = -1, vcount = 0;
  bit finished = 0;

  function automatic int lim_of(int p);
    return (p * 166) / 256;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int k, eg, ea;
    k  = imin(imin(m_duty, m_ceil), lim_of(m_per));
    eg = (en && !m_trip && (m_cnt + k > m_per)) ? 1 : 0;
    ea = (en && m_cnt == m_per) ? 1 : 0;
    chk("R1", "gate", int'(gate), eg);
    chk("R2", "adc trigger", int'(adc), ea);
    chk("R7", "trip latch", int'(trip_act), m_trip);
    chk("R8", "trip flag", int'(tflag), m_flag);
    chk("R9", "ramp done", int'(rdone), (m_ceil >= lim_of(m_per)) ? 1 : 0);
    if (m_cnt == 0) begin
      last_width = gacc;
      gacc = 0;
      since_v = 0;
      vcount++;
    end else begin
      since_v++;
    end
    if (gate) gacc++;
    if (adc) adc_pos = since_v;
  endtask

  task automatic model_step();
    int v, old;
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_per = 2; m_duty = 0; m_ceil = 0; m_rc = 0; m_trip = 0; m_flag = 0;
      return;
    end
    v = (m_cnt == 0);
    m_flag = (en && !v && oc) || (m_flag && !clr);
    if (!en || v) m_trip = 0;
    else if (oc)  m_trip = 1;
    if (!en) begin
      m_ceil = 0; m_rc = 0;
    end else if (v) begin
      if (m_rc == RP - 1) begin
        m_rc = 0;
        m_ceil = imin(m_ceil + int'(step), lim_of(m_per));
      end else m_rc++;
    end
    old = m_cnt;
    if (!en) begin
      m_cnt = 0; m_up = 1;
    end else if (m_up) begin
      if (m_cnt >= m_per) begin m_cnt--; m_up = 0; end
      else m_cnt++;
    end else begin
      m_cnt--;
      if (old == 1) m_up = 1;
    end
    if (v) begin
      m_per = (int'(per) < 2) ? 2 : int'(per);
      m_duty = int'(duty);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    rst_n = s_rst_n[0]; en = s_en[0]; duty = CW'(s_duty); per = CW'(s_per);
    step = SW'(s_step); oc = s_oc[0]; clr = s_clr[0];
    #5;
    compare();
    @(posedge clk);
    model_step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_valleys(int n);
    int target;
    target = vcount + n;
    while (vcount < target) tick();
  endtask

  task automatic run_until_cnt(int c, int up);
    while (!(m_cnt == c && m_up == up)) tick();
  endtask

  initial begin
    // R10: reset state
    ticks(3);
    #5;
    chk("R10", "gate in reset", int'(gate), 0);
    chk("R10", "adc in reset", int'(adc), 0);
    chk("R10", "flag in reset", int'(tflag), 0);
    chk("R10", "ramp done in reset", int'(rdone), 0);

    s_rst_n = 1; s_per = 20; s_duty = 10; s_step = 3;
    ticks(2);
    s_en = 1;
    wait_valleys(1);
    wait_valleys(1);
    chk("R5", "first period width after enable", last_width, 0);
    wait_valleys(18);
    chk("R1", "settled width duty 10", last_width, 19);
    chk("R2", "adc position after valley", adc_pos, 20);

    s_duty = 15;
    wait_valleys(2);
    chk("R4", "width capped by max limit", last_width, 23);
    #5;
    chk("R9", "ramp done after ramp", int'(rdone), 1);

    // R3: change duty part-way through a pulse
    run_until_cnt(5, 1);
    s_duty = 4;
    wait_valleys(1);
    chk("R3", "width in period of change", last_width, 23);
    wait_valleys(1);
    chk("R3", "width after shadow load", last_width, 7);

    // R7 / R8: mid-pulse trip
    s_duty = 12;
    wait_valleys(2);
    run_until_cnt(15, 1);
    s_oc = 1;
    tick();
    s_oc = 0;
    #5;
    chk("R7", "latch set after trip", int'(trip_act), 1);
    chk("R7", "gate blanked after trip", int'(gate), 0);
    wait_valleys(1);
    chk("R7", "truncated width", last_width, 7);
    wait_valleys(1);
    chk("R7", "width after latch clear", last_width, 23);
    #5;
    chk("R8", "flag still held", int'(tflag), 1);
    s_clr = 1;
    tick();
    s_clr = 0;
    #5;
    chk("R8", "flag cleared", int'(tflag), 0);

    // R7: overcurrent in the valley cycle is ignored
    run_until_cnt(0, 1);
    s_oc = 1;
    tick();
    s_oc = 0;
    #5;
    chk("R7", "no latch from valley trip", int'(trip_act), 0);
    chk("R8", "no flag from valley trip", int'(tflag), 0);

    // R8: trip and clear together
    run_until_cnt(10, 1);
    s_oc = 1; s_clr = 1;
    tick();
    s_oc = 0; s_clr = 0;
    #5;
    chk("R8", "set beats clear", int'(tflag), 1);
    s_clr = 1;
    tick();
    s_clr = 0;

    // R6 / R5: disable then re-enable restarts the ramp
    s_en = 0;
    ticks(3);
    #5;
    chk("R6", "gate while disabled", int'(gate), 0);
    chk("R6", "adc while disabled", int'(adc), 0);
    chk("R6", "ramp reset while disabled", int'(rdone), 0);
    s_en = 1;
    wait_valleys(1);
    wait_valleys(1);
    chk("R5", "width right after re-enable", last_width, 0);
    wait_valleys(3);
    chk("R5", "width after first ramp step", last_width, 5);

    // R1: period below the minimum is clamped to 2
    s_per = 1;
    wait_valleys(2);
    chk("R1", "width at clamped period", last_width, 1);
    chk("R2", "adc position at clamped period", adc_pos, 2);
    ticks(8);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule